// File: doc/BRIEF.md
# Pipelined Single-Precision Square Root

This block takes a stream of 32-bit single-precision floating-point operands and returns their square roots as a stream of 32-bit single-precision results. A new operand may be offered on every clock cycle. Each result appears a fixed number of cycles after its operand, and results leave in the order their operands entered. There is no stall path: whatever is accepted is always delivered.

The significand root is produced by a non-restoring recurrence. Each step adds or subtracts a correction term, chosen by the sign of the current partial remainder. The recurrence is unrolled over thirteen pipeline stages, and each stage holds its own pair of adder/subtracters, so every stage settles two root bits. An unpack stage comes before the recurrence and a round-and-pack stage comes after it. The sign, the halved exponent and a special-value class travel in side registers next to the significand datapath. Results are rounded to nearest, with ties going to even. Subnormal operands are treated as zero.

Top module: `fp_sqrt_pipe`

## Requirements
- R1: An operand presented with `in_valid` high in cycle t gives `out_valid` high in cycle t+15 and no other cycle, and `out_valid` is never high without such an operand.
- R2: Operands may be presented on consecutive cycles without gaps, and results come out in the same order, one per cycle.
- R3: For a positive normal operand the result is the square root rounded to nearest-even, with sign bit 31 equal to 0. The only result with bit 31 set is a negative zero.
- R4: The square root of a value that is an exact square in single precision is returned exactly (4.0 gives 2.0, 9.0 gives 3.0, 0.25 gives 0.5, 1.0 gives 1.0).
- R5: The result exponent field (bits 30:23) of a positive normal operand with exponent field E equals (E+127)>>1, for both even and odd unbiased exponents.
- R6: +0 (0x00000000) gives +0 and -0 (0x80000000) gives -0.
- R7: +infinity (0x7F800000) gives +infinity.
- R8: Any NaN operand (exponent field 0xFF, nonzero fraction, either sign) gives the quiet NaN 0x7FC00000.
- R9: A negative operand that is normal or -infinity (0xFF800000) gives 0x7FC00000.
- R10: A subnormal operand (exponent field 0, nonzero fraction) gives a zero that keeps the operand's sign.
- R11: While `rst_n` is low, and for 15 cycles after it rises with no operand offered, `out_valid` stays low, whatever `in_valid` did during reset.
- R12: The extremes of the normal range are handled: 0x7F7FFFFF gives 0x5F7FFFFF and 0x00800000 gives 0x20000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the valid chain |
| in_valid | input | 1 | Operand qualifier |
| in_data | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 32 | Single-precision square root |

## Verification
Accepting a new operand and delivering the result of an operand taken fifteen cycles earlier happen in the same cycle whenever the input stream is longer than the pipeline. A run of several hundred back-to-back random operands, followed by a stream where zeros, infinities, NaNs and negatives are mixed between normal values, keeps both activities busy at once. A queue in the bench holds the expected value and the due cycle of every accepted operand. Each delivered result must match the head of that queue in both value and cycle, so a lost, duplicated, reordered or late result is caught, as is a special class that leaks into a neighbouring lane.

// File: rtl/fp_sqrt_pipe.sv
module fp_sqrt_pipe (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic [31:0] out_data
);
  localparam int NSTG = 13;
  localparam int QW   = 2 * NSTG;
  localparam int XW   = 4 * NSTG;
  localparam int RW   = QW + 4;
  localparam logic [1:0] K_NUM = 2'd0, K_ZERO = 2'd1, K_INF = 2'd2, K_NAN = 2'd3;

  function automatic logic [RW+QW-1:0] nr_step(input logic [RW-1:0] r,
                                               input logic [QW-1:0] q,
                                               input logic [1:0]    b);
    logic [RW-1:0] t, rn;
    t = {r[RW-3:0], b};
    if (!r[RW-1]) rn = t - {{(RW-QW-2){1'b0}}, q, 2'b01};
    else          rn = t + {{(RW-QW-2){1'b0}}, q, 2'b11};
    return {rn, q[QW-2:0], ~rn[RW-1]};
  endfunction

  logic [7:0]  in_exp;
  logic [22:0] in_frac;
  logic [1:0]  in_kind;
  logic [8:0]  exp_sum;
  assign in_exp  = in_data[30:23];
  assign in_frac = in_data[22:0];
  assign exp_sum = {1'b0, in_exp} + 9'd127;

  always_comb begin
    if (in_exp == 8'hFF && in_frac != 23'd0) in_kind = K_NAN;
    else if (in_exp == 8'h00)                in_kind = K_ZERO;
    else if (in_data[31])                    in_kind = K_NAN;
    else if (in_exp == 8'hFF)                in_kind = K_INF;
    else                                     in_kind = K_NUM;
  end

  logic        vld  [0:NSTG];
  logic [1:0]  kind [0:NSTG];
  logic        sgn  [0:NSTG];
  logic [7:0]  exh  [0:NSTG];
  logic [23:0] man  [0:NSTG];
  logic        odd  [0:NSTG];
  logic [RW-1:0] rem  [1:NSTG];
  logic [QW-1:0] root [1:NSTG];

  always_ff @(posedge clk) begin
    if (!rst_n) vld[0] <= 1'b0;
    else        vld[0] <= in_valid;
  end

  always_ff @(posedge clk) begin
    kind[0] <= in_kind;
    sgn[0]  <= in_data[31];
    exh[0]  <= exp_sum[8:1];
    man[0]  <= {1'b1, in_frac};
    odd[0]  <= ~in_exp[0];
  end

  for (genvar s = 1; s <= NSTG; s++) begin : g_stg
    logic [RW-1:0]    r_in;
    logic [QW-1:0]    q_in;
    logic [XW-1:0]    xr;
    logic [3:0]       nib;
    logic [RW+QW-1:0] st1, st2;

    if (s == 1) begin : g_first
      assign r_in = '0;
      assign q_in = '0;
    end else begin : g_next
      assign r_in = rem[s-1];
      assign q_in = root[s-1];
    end

    assign xr  = odd[s-1] ? {man[s-1], {(XW-24){1'b0}}}
                          : {1'b0, man[s-1], {(XW-25){1'b0}}};
    assign nib = 4'(xr >> (XW - 4 * s));
    assign st1 = nr_step(r_in, q_in, nib[3:2]);
    assign st2 = nr_step(st1[RW+QW-1:QW], st1[QW-1:0], nib[1:0]);

    always_ff @(posedge clk) begin
      if (!rst_n) vld[s] <= 1'b0;
      else        vld[s] <= vld[s-1];
    end

    always_ff @(posedge clk) begin
      rem[s]  <= st2[RW+QW-1:QW];
      root[s] <= st2[QW-1:0];
      kind[s] <= kind[s-1];
      sgn[s]  <= sgn[s-1];
      exh[s]  <= exh[s-1];
      man[s]  <= man[s-1];
      odd[s]  <= odd[s-1];
    end
  end

  logic [QW-1:0] q_f;
  logic [RW-1:0] r_f, r_fix;
  logic          rem_nz, rnd_up;
  logic [31:0]   num_res, res_c;

  assign q_f     = root[NSTG];
  assign r_f     = rem[NSTG];
  assign r_fix   = r_f + {{(RW-QW-1){1'b0}}, q_f, 1'b1};
  assign rem_nz  = r_f[RW-1] ? (r_fix != '0) : (r_f != '0);
  assign rnd_up  = q_f[1] & (q_f[0] | rem_nz | q_f[2]);
  assign num_res = {1'b0, exh[NSTG], q_f[QW-2:2]} + {31'd0, rnd_up};

  always_comb begin
    case (kind[NSTG])
      K_NUM:   res_c = num_res;
      K_ZERO:  res_c = {sgn[NSTG], 31'd0};
      K_INF:   res_c = 32'h7F80_0000;
      default: res_c = 32'h7FC0_0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld[NSTG];
  end

  always_ff @(posedge clk) out_data <= res_c;
endmodule

// File: rtl/fp_sqrt_pipe_chk.sv
module fp_sqrt_pipe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic [31:0] out_data
);
  logic [4:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)            age <= 5'd0;
    else if (age != 5'd15) age <= age + 5'd1;
  end

  logic warm, e_ff, e_00, f_nz;
  assign warm = (age == 5'd15);
  assign e_ff = (in_data[30:23] == 8'hFF);
  assign e_00 = (in_data[30:23] == 8'h00);
  assign f_nz = (in_data[22:0] != 23'd0);

  logic i_nan, i_neg, i_zero, i_sub, i_pinf, i_num;
  assign i_nan  = in_valid && e_ff && f_nz;
  assign i_neg  = in_valid && in_data[31] && !e_00 && !(e_ff && f_nz);
  assign i_zero = in_valid && e_00 && !f_nz;
  assign i_sub  = in_valid && e_00 && f_nz;
  assign i_pinf = in_valid && (in_data == 32'h7F80_0000);
  assign i_num  = in_valid && !in_data[31] && !e_00 && !e_ff;

  logic [8:0] exp_plus;
  assign exp_plus = {1'b0, in_data[30:23]} + 9'd127;

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 15)));

  assert_only_negzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[31]) |-> (out_data[30:0] == 31'd0));

  assert_exp_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(i_num, 15)) |-> (out_data[30:23] == $past(exp_plus[8:1], 15)));

  assert_zero_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(i_zero, 15)) |-> (out_data == $past(in_data, 15)));

  assert_inf_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(i_pinf, 15)) |-> (out_data == 32'h7F80_0000));

  assert_nan_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(i_nan, 15)) |-> (out_data == 32'h7FC0_0000));

  assert_neg_nan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(i_neg, 15)) |-> (out_data == 32'h7FC0_0000));

  assert_sub_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(i_sub, 15)) |-> (out_data == {$past(in_data[31], 15), 31'd0}));

  assert_idle_reset_R11: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind fp_sqrt_pipe fp_sqrt_pipe_chk u_chk (.*);

// File: tb/fp_sqrt_pipe_bench.sv
module fp_sqrt_pipe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  fp_sqrt_pipe u_fp_sqrt_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] model(input logic [31:0] x);
    logic [63:0] d, db;
    logic [10:0] e2;
    logic [22:0] m;
    logic        g, st;
    real         rv;
    if (x[30:23] == 8'hFF && x[22:0] != 0) return 32'h7FC0_0000;
    if (x[30:23] == 8'h00)                 return {x[31], 31'd0};
    if (x[31])                             return 32'h7FC0_0000;
    if (x[30:23] == 8'hFF)                 return 32'h7F80_0000;
    d  = {1'b0, 11'({3'b0, x[30:23]} + 11'd896), x[22:0], 29'd0};
    rv = $sqrt($bitstoreal(d));
    db = $realtobits(rv);
    e2 = db[62:52];
    m  = db[51:29];
    g  = db[28];
    st = |db[27:0];
    return {1'b0, 8'(e2 - 11'd896), m} + {31'd0, g & (st | m[0])};
  endfunction

  task automatic fail_msg(input string req, input logic [31:0] act, input logic [31:0] expv);
    errors++;
    $display("FAIL %s actual=%08h expected=%08h (cycle %0d)", req, act, expv, cyc);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          checks++;
          fail_msg("R1 spurious out_valid", out_data, 32'd0);
        end else begin
          checks += 2;
          if (due_q[0] != cyc) fail_msg("R1 latency", 32'(cyc), 32'(due_q[0]));
          if (out_data !== exp_q[0]) fail_msg(tag_q[0], out_data, exp_q[0]);
          void'(exp_q.pop_front());
          void'(due_q.pop_front());
          void'(tag_q.pop_front());
        end
      end else if (exp_q.size() != 0 && due_q[0] <= cyc) begin
        checks++;
        fail_msg("R1 missing out_valid", 32'd0, exp_q[0]);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic issue(input logic [31:0] x, input logic [31:0] expv, input string tag);
    in_valid = 1'b1;
    in_data  = x;
    exp_q.push_back(expv);
    due_q.push_back(cyc + LAT);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  // R11: reset holds output idle even with in_valid high during reset
  task automatic t_reset();
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_data  = 32'h4080_0000;
    repeat (5) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) fail_msg("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n    = 1'b1;
    in_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      checks++;
      if (out_valid !== 1'b0) fail_msg("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
    end
  endtask

  // R4 R5 R12 R3: known constants, issued one at a time
  task automatic t_known();
    issue(32'h4080_0000, 32'h4000_0000, "R4 sqrt(4)");    drain();
    issue(32'h4110_0000, 32'h4040_0000, "R4 sqrt(9)");    drain();
    issue(32'h3E80_0000, 32'h3F00_0000, "R4 sqrt(0.25)"); drain();
    issue(32'h3F80_0000, 32'h3F80_0000, "R4 sqrt(1)");    drain();
    issue(32'h4000_0000, 32'h3FB5_04F3, "R5 sqrt(2)");    drain();
    issue(32'h4100_0000, 32'h4035_04F3, "R5 sqrt(8)");    drain();
    issue(32'h4040_0000, 32'h3FDD_B3D7, "R3 sqrt(3)");    drain();
    issue(32'h4120_0000, 32'h404A_62C2, "R3 sqrt(10)");   drain();
    issue(32'h7F7F_FFFF, 32'h5F7F_FFFF, "R12 max normal"); drain();
    issue(32'h0080_0000, 32'h2000_0000, "R12 min normal"); drain();
  endtask

  // R6 R7 R8 R9 R10: special classes
  task automatic t_special();
    issue(32'h0000_0000, 32'h0000_0000, "R6 +0");
    issue(32'h8000_0000, 32'h8000_0000, "R6 -0");
    issue(32'h7F80_0000, 32'h7F80_0000, "R7 +inf");
    issue(32'h7FC0_0000, 32'h7FC0_0000, "R8 qnan");
    issue(32'h7F80_0001, 32'h7FC0_0000, "R8 snan");
    issue(32'hFFC1_2345, 32'h7FC0_0000, "R8 neg nan");
    issue(32'hBF80_0000, 32'h7FC0_0000, "R9 -1.0");
    issue(32'hFF80_0000, 32'h7FC0_0000, "R9 -inf");
    issue(32'h0000_0001, 32'h0000_0000, "R10 +subnormal");
    issue(32'h807F_FFFF, 32'h8000_0000, "R10 -subnormal");
    drain();
  endtask

  // R2 R3 R5: back-to-back random positive normals
  task automatic t_stream();
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x;
      logic [7:0]  e;
      e = 8'(1 + ($urandom % 254));
      x = {1'b0, e, 23'($urandom)};
      issue(x, model(x), "R2/R3 stream");
    end
    drain();
  endtask

  // R2 R8 R9 R6: specials mixed between normals, no gaps
  task automatic t_mixed();
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x;
      case ($urandom % 6)
        0: x = {1'b0, 8'(1 + ($urandom % 254)), 23'($urandom)};
        1: x = {1'b1, 8'(1 + ($urandom % 254)), 23'($urandom)};
        2: x = {1'($urandom), 8'h00, 23'($urandom % 4)};
        3: x = {1'($urandom), 8'hFF, 23'($urandom % 2)};
        default: x = {1'b0, 8'(100 + ($urandom % 56)), 23'($urandom)};
      endcase
      issue(x, model(x), "R2 mixed");
    end
    drain();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_known();
    t_special();
    t_stream();
    t_mixed();
    checks++;
    if (exp_q.size() != 0) fail_msg("R1 undelivered results", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule